// File: doc/BRIEF.md
# Serial Frame Position Tracker

This block follows where a serial bit stream currently sits inside its frame. It runs on the data clock and advances one bit slot per cycle. Two frame layouts are supported. The short layout has 24 eight-bit channels with one framing bit in front, 193 slots in all, and runs at 1.544 MHz. The long layout has 32 eight-bit channels and no framing bit, 256 slots in all, and runs at 2.048 MHz. Both layouts give an 8 kHz frame rate.

A rising edge on the sync input sets the frame phase. After that the internal counter keeps the phase on its own. The sync line may pulse once, or every frame, and each later rising edge realigns the counter to that edge.

The block outputs:
- the channel index and the bit index within that channel;
- a frame-start strobe;
- a strobe for the framing-bit slot;
- a channel clock that rises at the start of each channel;
- a flag that stays high until the first alignment.

Downstream logic uses these outputs to place bytes and to find frame boundaries.

Top module: `frame_pos_tracker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset is released, the outputs show frame slot 0: `frame_start`=1, `unlocked`=1, `chan_idx`=0, `bit_idx`=0, and `fbit`=1 when `mode_long` was 0 during reset.
- R2: A rising sync edge is seen at a clock edge where `sync_in` is sampled 1 after being sampled 0 at the previous edge. Right after that clock edge the outputs show slot 0 (`frame_start`=1), whatever the previous position was.
- R3: Holding `sync_in` high does not realign the counter again. The position keeps advancing by one slot per cycle.
- R4: With `mode_long`=0 and no further sync edges, `frame_start` recurs every 193 cycles.
- R5: With `mode_long`=1 and no further sync edges, `frame_start` recurs every 256 cycles.
- R6: With `mode_long`=0, slot 0 is the framing bit: `fbit`=1, `chan_idx`=0, `bit_idx`=0. Slot p≥1 maps to `chan_idx`=(p-1)/8 and `bit_idx`=(p-1)%8, and `fbit`=0 there.
- R7: With `mode_long`=1, slot p maps to `chan_idx`=p/8 and `bit_idx`=p%8, and `fbit` is always 0.
- R8: `chan_clk` is 1 when `bit_idx` is 0 to 3 and 0 when `bit_idx` is 4 to 7. It is also 0 in the framing-bit slot, so it rises exactly at bit 0 of each channel.
- R9: `unlocked` stays 1 from reset until the first rising sync edge. After that edge it is 0 and stays 0 until the next reset.
- R10: `mode_long` is sampled only during reset, at a sync edge, or when the counter wraps to slot 0. A change in the middle of a frame first takes effect at the following slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial data clock, one bit slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_long | input | 1 | 0 = 193-slot layout with framing bit, 1 = 256-slot layout |
| sync_in | input | 1 | Frame sync; a rising edge marks slot 0 |
| chan_idx | output | 5 | Current channel number |
| bit_idx | output | 3 | Current bit within the channel |
| frame_start | output | 1 | High during slot 0 of each frame |
| fbit | output | 1 | High during the framing-bit slot (193-slot layout only) |
| chan_clk | output | 1 | Channel clock, high for the first half of each channel |
| unlocked | output | 1 | High until the first sync edge after reset |

## Verification
All position outputs are decoded directly from registers, so each result is due in the cycle that follows the clock edge causing it. A sync edge sampled at edge k shows slot 0 just after edge k, and slot n appears n edges later. The bench drives inputs and samples outputs one time unit after each rising edge, so every check reads the state left by the edge just passed. Frame-length and mode-change checks count edges from a known slot 0 up to the next `frame_start`, rather than relying on absolute times.

// File: rtl/frame_pos_pkg.sv
// Shared definitions for the frame position tracker.
// Assumes eight-bit channels; the frame geometry is set by parameters on the top module.
package frame_pos_pkg;
    typedef enum logic {
        LAYOUT_SHORT = 1'b0,   // 193-slot frame with a leading framing bit
        LAYOUT_LONG  = 1'b1    // 256-slot frame, channels only
    } layout_e;
endpackage

// File: rtl/fpt_sync_edge.sv
// Sync edge detector and lock flag.
// Keeps a registered copy of sync_in, including during reset, so an edge is a 0->1 change
// between two consecutive samples. A level that stays high is not an edge.
module fpt_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic edge_seen,
    output logic unlocked
);
    logic sync_q;

    // Remember the previous sample of the sync line.
    always_ff @(posedge clk) begin
        sync_q <= sync_in;
    end

    assign edge_seen = sync_in & ~sync_q;

    // Lock flag: set by reset, cleared by the first sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b1;
        else if (edge_seen)
            unlocked <= 1'b0;
    end
endmodule

// File: rtl/fpt_slot_counter.sv
// Free-running slot counter with layout latch.
// Assumes SHORT_LEN <= LONG_LEN <= 2**POS_W. The counter restarts at slot 0 on a sync edge
// or after the last slot of the current layout. The layout is latched only at those
// boundaries or during reset.
module fpt_slot_counter
    import frame_pos_pkg::*;
#(
    parameter int SHORT_LEN = 193,
    parameter int LONG_LEN  = 256,
    parameter int POS_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_long,
    input  logic             restart,
    output logic [POS_W-1:0] slot,
    output layout_e          layout
);
    localparam logic [POS_W-1:0] SHORT_LAST = POS_W'(SHORT_LEN - 1);
    localparam logic [POS_W-1:0] LONG_LAST  = POS_W'(LONG_LEN - 1);

    logic [POS_W-1:0] last_slot;
    logic             wrap;

    assign last_slot = (layout == LAYOUT_LONG) ? LONG_LAST : SHORT_LAST;
    assign wrap      = restart || (slot == last_slot);

    // Advance the slot position, returning to 0 at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (wrap)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    // Latch the layout select at reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap)
            layout <= layout_e'(mode_long);
    end
endmodule

// File: rtl/fpt_slot_decode.sv
// Slot decoder.
// Maps a slot number to channel and bit indices, the framing-bit strobe and the channel clock.
// In the short layout slot 0 is the framing bit and channel data starts at slot 1.
module fpt_slot_decode
    import frame_pos_pkg::*;
#(
    parameter int POS_W  = 8,
    parameter int BIT_W  = 3,
    parameter int CHAN_W = 5
) (
    input  logic [POS_W-1:0]  slot,
    input  layout_e           layout,
    output logic [CHAN_W-1:0] chan_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              frame_start,
    output logic              fbit,
    output logic              chan_clk
);
    localparam logic [BIT_W-1:0] HALF = BIT_W'(2 ** (BIT_W - 1));

    logic [POS_W-1:0] data_pos;

    // Remove the framing-bit offset and split the position into channel and bit.
    always_comb begin
        frame_start = (slot == '0);
        fbit        = frame_start && (layout == LAYOUT_SHORT);

        if (layout == LAYOUT_SHORT && !fbit)
            data_pos = slot - 1'b1;
        else
            data_pos = slot;

        bit_idx  = data_pos[BIT_W-1:0];
        chan_idx = data_pos[BIT_W +: CHAN_W];
        chan_clk = !fbit && (bit_idx < HALF);
    end
endmodule

// File: rtl/frame_pos_tracker.sv
// Frame position tracker: top level.
// Aligns to a rising sync edge and then keeps the frame phase on its own.
// Assumes one bit slot per clock and a sync line that is synchronous to clk.
module frame_pos_tracker
    import frame_pos_pkg::*;
#(
    parameter int CH_BITS     = 8,
    parameter int SHORT_CHANS = 24,
    parameter int LONG_CHANS  = 32,
    parameter int SHORT_EXTRA = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  mode_long,
    input  logic                                  sync_in,
    output logic [$clog2(LONG_CHANS)-1:0]         chan_idx,
    output logic [$clog2(CH_BITS)-1:0]            bit_idx,
    output logic                                  frame_start,
    output logic                                  fbit,
    output logic                                  chan_clk,
    output logic                                  unlocked
);
    localparam int SHORT_LEN = SHORT_CHANS * CH_BITS + SHORT_EXTRA;
    localparam int LONG_LEN  = LONG_CHANS * CH_BITS;
    localparam int BIT_W     = $clog2(CH_BITS);
    localparam int CHAN_W    = $clog2(LONG_CHANS);
    localparam int POS_W     = BIT_W + CHAN_W;

    logic             sync_edge;
    logic [POS_W-1:0] slot;
    layout_e          layout;

    fpt_sync_edge u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .edge_seen (sync_edge),
        .unlocked  (unlocked)
    );

    fpt_slot_counter #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .POS_W     (POS_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_long (mode_long),
        .restart   (sync_edge),
        .slot      (slot),
        .layout    (layout)
    );

    fpt_slot_decode #(
        .POS_W  (POS_W),
        .BIT_W  (BIT_W),
        .CHAN_W (CHAN_W)
    ) u_dec (
        .slot        (slot),
        .layout      (layout),
        .chan_idx    (chan_idx),
        .bit_idx     (bit_idx),
        .frame_start (frame_start),
        .fbit        (fbit),
        .chan_clk    (chan_clk)
    );
endmodule

// File: rtl/frame_pos_tracker_sva.sv
// Property checker for the frame position tracker, attached with bind.
// Watches only the top-level ports.
module frame_pos_tracker_sva #(
    parameter int BIT_W  = 3,
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_in,
    input logic [CHAN_W-1:0] chan_idx,
    input logic [BIT_W-1:0]  bit_idx,
    input logic              frame_start,
    input logic              fbit,
    input logic              chan_clk,
    input logic              unlocked
);
    // R2: a rising sync edge puts the tracker at slot 0.
    p_sync_aligns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_in) |=> frame_start);

    // R4 / R5: a frame is longer than one slot, so slot 0 never repeats without a sync edge.
    p_no_double_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !$rose(sync_in)) |=> !frame_start);

    // R6: the framing bit only occurs at slot 0, which reads as channel 0, bit 0.
    p_fbit_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fbit |-> (frame_start && chan_idx == '0 && bit_idx == '0));

    // R8: the channel clock is high only in the first half of a channel.
    p_chanclk_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk |-> (bit_idx < BIT_W'(4) && !fbit));

    // R9: once locked, the tracker stays locked.
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> !unlocked);
endmodule

bind frame_pos_tracker frame_pos_tracker_sva #(
    .BIT_W  ($clog2(CH_BITS)),
    .CHAN_W ($clog2(LONG_CHANS))
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_in     (sync_in),
    .chan_idx    (chan_idx),
    .bit_idx     (bit_idx),
    .frame_start (frame_start),
    .fbit        (fbit),
    .chan_clk    (chan_clk),
    .unlocked    (unlocked)
);

// File: tb/frame_pos_tracker_tb.sv
// Self-checking bench for frame_pos_tracker: a table walk, then directed cases.
module frame_pos_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_long = 1'b0;
    logic       sync_in = 1'b0;
    logic [4:0] chan_idx;
    logic [2:0] bit_idx;
    logic       frame_start, fbit, chan_clk, unlocked;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frame_pos_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .sync_in(sync_in),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_start(frame_start),
        .fbit(fbit), .chan_clk(chan_clk), .unlocked(unlocked)
    );

    // Vector: {layout, slot[8:0], chan[4:0], bit[2:0], fbit, chan_clk}
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 9'd0,   5'd0,  3'd0, 1'b1, 1'b0},  // R6 framing bit
        {1'b0, 9'd1,   5'd0,  3'd0, 1'b0, 1'b1},  // R6 first data bit, R8
        {1'b0, 9'd4,   5'd0,  3'd3, 1'b0, 1'b1},  // R8 last high bit
        {1'b0, 9'd5,   5'd0,  3'd4, 1'b0, 1'b0},  // R8 first low bit
        {1'b0, 9'd9,   5'd1,  3'd0, 1'b0, 1'b1},  // R6 channel 1
        {1'b0, 9'd192, 5'd23, 3'd7, 1'b0, 1'b0},  // R6 last slot
        {1'b1, 9'd0,   5'd0,  3'd0, 1'b0, 1'b1},  // R7 no framing bit
        {1'b1, 9'd7,   5'd0,  3'd7, 1'b0, 1'b0},  // R7
        {1'b1, 9'd8,   5'd1,  3'd0, 1'b0, 1'b1},  // R7 channel boundary
        {1'b1, 9'd100, 5'd12, 3'd4, 1'b0, 1'b0},  // R7
        {1'b1, 9'd255, 5'd31, 3'd7, 1'b0, 1'b0}   // R7 last slot
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0; mode_long = m; sync_in = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // Raise sync so that the next edge detects it; afterwards the outputs show slot 0.
    task automatic align();
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Count edges until frame_start is seen again (the caller starts at slot 0).
    task automatic frame_len(output int len);
        len = 0;
        do begin
            tick();
            len++;
        end while (!frame_start && len < 400);
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int len;
        tick();

        // Table walk: R6, R7, R8 mapping at chosen slots.
        for (int v = 0; v < NV; v++) begin
            do_reset(VEC[v][19]);
            tick();
            align();
            advance(int'(VEC[v][18:10]));
            check("R6/R7 chan_idx",  chan_idx, int'(VEC[v][9:5]));
            check("R6/R7 bit_idx",   bit_idx,  int'(VEC[v][4:2]));
            check("R6/R7 fbit",      fbit,     int'(VEC[v][1]));
            check("R8 chan_clk",     chan_clk, int'(VEC[v][0]));
        end

        // R1: reset state.
        rst_n = 1'b0; mode_long = 1'b0; sync_in = 1'b0;
        tick(); tick();
        check("R1 frame_start in reset", frame_start, 1);
        check("R1 unlocked in reset", unlocked, 1);
        check("R1 fbit in reset", fbit, 1);
        rst_n = 1'b1;
        tick();
        check("R1 chan_idx after reset", chan_idx, 0);
        check("R1 bit_idx after reset", bit_idx, 0);

        // R9: stays unlocked without a sync edge.
        do_reset(1'b0);
        advance(300);
        check("R9 unlocked before sync", unlocked, 1);
        align();
        check("R9 locked after sync", unlocked, 0);
        check("R2 frame_start after sync", frame_start, 1);

        // R4: short frame length without sync.
        frame_len(len);
        check("R4 short frame length", len, 193);
        frame_len(len);
        check("R4 second short frame", len, 193);
        check("R9 still locked", unlocked, 0);

        // R5: long frame length.
        do_reset(1'b1);
        align();
        frame_len(len);
        check("R5 long frame length", len, 256);

        // R2: realign in the middle of a frame.
        do_reset(1'b0);
        align();
        advance(50);
        check("R2 mid-frame not at start", frame_start, 0);
        align();
        check("R2 realign frame_start", frame_start, 1);
        check("R2 realign fbit", fbit, 1);

        // R3: sync held high does not realign again.
        do_reset(1'b0);
        sync_in = 1'b1;
        tick();
        check("R3 first edge aligns", frame_start, 1);
        advance(10);
        check("R3 held high no realign", frame_start, 0);
        check("R3 held high chan_idx", chan_idx, 1);
        check("R3 held high bit_idx", bit_idx, 1);
        sync_in = 1'b0;

        // R10: a mode change in the middle of a frame waits for the next slot 0.
        do_reset(1'b0);
        align();
        advance(20);
        mode_long = 1'b1;
        tick();
        check("R10 short mapping kept chan", chan_idx, 2);
        check("R10 short mapping kept bit", bit_idx, 4);
        frame_len(len);
        check("R10 old frame length kept", len, 172);
        check("R10 new layout has no fbit", fbit, 0);
        frame_len(len);
        check("R10 new frame length", len, 256);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule